// File: doc/BRIEF.md
# Even-Odd Split Carry-Save Multiplier

This block multiplies two unsigned operands and returns the full double-width product. Each operand is first split into two numbers of the same width: one keeps only the bits at even positions and the other keeps only the bits at odd positions, with zeros everywhere else. The four cross products of those numbers (even by even, even by odd, odd by even, odd by odd) add up to the complete product. Their sparse partial-product rows are merged in one pool.

The pool of rows is reduced by successive layers of 3-to-2 carry-save compressors, with no carry chain anywhere, until exactly two rows remain. A carry-look-ahead adder adds those two rows. It uses generate/propagate terms in 4-bit groups and a second look-ahead level across the groups. A parameter selects whether the product goes straight to the output or through one output register. That register has a synchronous, active-high reset. The block is meant as a drop-in arithmetic unit wherever a wide unsigned product is needed in one cycle.

Top module: `eo_mult`

## Requirements
- R1: `p` equals the unsigned product of `a` and `b` in full 64-bit width with no truncation; for example, all-ones times all-ones gives 0xFFFFFFFE00000001.
- R2: Each operand is split into an even number, which holds the bits at positions 0, 2, 4 and so on, and an odd number, which holds the bits at positions 1, 3, 5 and so on. The two numbers share no set bit, and their OR is the operand.
- R3: The product is exact when one half of an operand is all zeros. This covers the alternating patterns 0x55555555 and 0xAAAAAAAA and any operand masked to only even bits or only odd bits.
- R4: Every 3-to-2 layer preserves the arithmetic sum of its rows modulo 2^64. Rows left over when the count is not a multiple of three pass unchanged, and the tree ends in exactly two rows.
- R5: The final adder is a two-level carry-look-ahead adder over 4-bit groups, and its result equals the true sum of the two remaining rows.
- R6: With the output register enabled (the default), `p` shows the product of the inputs sampled at a rising edge of `clk` from that edge on. It holds that value until the next edge, even if the inputs change.
- R7: While `rst` is high at a rising edge, `p` becomes zero on that edge, whatever the inputs are.
- R8: When each operand has a single set bit, at positions i and j, `p` has a single set bit at position i+j.
- R9: A zero operand gives a zero product, and an operand of one gives the other operand, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset that clears the output register |
| a | input | 32 | Unsigned multiplicand |
| b | input | 32 | Unsigned multiplier |
| p | output | 64 | Unsigned 64-bit product |

## Verification
A wrong internal state corrupts the product almost at once. A bad even/odd mask drops or doubles a row. A faulty compressor bit or a missing leftover row shifts the sum of the tree. A broken group carry flips a run of high bits. With the output register, each of these shows at `p` one edge after the offending operands are applied. Alternating and single-bit operands empty whole quarters of the partial-product pool, so they expose faults that dense random operands can hide. The bench checks them explicitly, on top of a long random run.

// File: rtl/eomul_pkg.sv
package eomul_pkg;

   // Rows left after lv layers of 3-to-2 compression, starting from n rows.
   function automatic int rows_after(input int n, input int lv);
      int r;
      r = n;
      for (int i = 0; i < lv; i++) r = 2 * (r / 3) + (r % 3);
      return r;
   endfunction

   // Number of layers needed to bring n rows down to two.
   function automatic int tree_depth(input int n);
      int r;
      int d;
      r = n;
      d = 0;
      while (r > 2) begin
         r = 2 * (r / 3) + (r % 3);
         d++;
      end
      return d;
   endfunction

endpackage

// File: rtl/eomul_split.sv
module eomul_split #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] x,
   output logic [W-1:0] x_even,
   output logic [W-1:0] x_odd
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i % 2 == 0) begin : g_ev
         assign x_even[i] = x[i];
         assign x_odd[i]  = 1'b0;
      end else begin : g_od
         assign x_even[i] = 1'b0;
         assign x_odd[i]  = x[i];
      end
   end

   AST_SPLIT_DISJOINT: assert property (@(posedge clk) disable iff (rst)
      (x_even & x_odd) == '0);                                       // R2
   AST_SPLIT_COVER: assert property (@(posedge clk) disable iff (rst)
      (x_even | x_odd) == x);                                        // R2

endmodule

// File: rtl/eomul_ppgen.sv
module eomul_ppgen #(
   parameter int W = 32,
   localparam int PW = 2 * W,
   localparam int NR = 2 * W
) (
   input  logic [W-1:0]  a_even,
   input  logic [W-1:0]  a_odd,
   input  logic [W-1:0]  b_even,
   input  logic [W-1:0]  b_odd,
   output logic [PW-1:0] rows [NR]
);

   localparam int HALF = W / 2;

   // q: 0 even*even, 1 even*odd, 2 odd*even, 3 odd*odd
   for (genvar q = 0; q < 4; q++) begin : g_pair
      logic [W-1:0] mcand;
      logic [W-1:0] mplier;
      assign mcand  = (q < 2)      ? a_even : a_odd;
      assign mplier = (q % 2 == 0) ? b_even : b_odd;
      for (genvar i = 0; i < HALF; i++) begin : g_row
         localparam int J = 2 * i + (q % 2);
         assign rows[q*HALF + i] = mplier[J] ? ({{W{1'b0}}, mcand} << J) : '0;
      end
   end

endmodule

// File: rtl/eomul_csa_tree.sv
module eomul_csa_tree
   import eomul_pkg::*;
#(
   parameter int PW = 64,
   parameter int N  = 64
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] rows [N],
   output logic [PW-1:0] row_s,
   output logic [PW-1:0] row_c
);

   localparam int DEPTH = tree_depth(N);

   if (N < 3) begin : g_chk_n
      $error("eomul_csa_tree: N must be at least 3");
   end
   if (rows_after(N, DEPTH) != 2) begin : g_chk_end
      $error("eomul_csa_tree: tree does not end in two rows");
   end

   for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl
      localparam int RI = rows_after(N, lv);
      localparam int RO = rows_after(N, lv + 1);
      localparam int NG = RI / 3;
      logic [PW-1:0] cur [RI];
      logic [PW-1:0] nxt [RO];
      logic [PW-1:0] sum_in;
      logic [PW-1:0] sum_out;

      for (genvar k = 0; k < RI; k++) begin : g_in
         if (lv == 0) begin : g_top
            assign cur[k] = rows[k];
         end else begin : g_chain
            assign cur[k] = g_lvl[lv-1].nxt[k];
         end
      end

      for (genvar g = 0; g < NG; g++) begin : g_fa
         logic [PW-1:0] fx, fy, fz;
         assign fx = cur[3*g];
         assign fy = cur[3*g + 1];
         assign fz = cur[3*g + 2];
         assign nxt[2*g]     = fx ^ fy ^ fz;
         assign nxt[2*g + 1] = ((fx & fy) | (fx & fz) | (fy & fz)) << 1;
      end

      for (genvar k = 0; k < RI % 3; k++) begin : g_pass
         assign nxt[2*NG + k] = cur[3*NG + k];
      end

      always_comb begin
         sum_in = '0;
         for (int k = 0; k < RI; k++) sum_in = sum_in + cur[k];
      end
      always_comb begin
         sum_out = '0;
         for (int k = 0; k < RO; k++) sum_out = sum_out + nxt[k];
      end

      AST_LEVEL_SUM: assert property (@(posedge clk) disable iff (rst)
         sum_in == sum_out);                                         // R4
   end

   assign row_s = g_lvl[DEPTH-1].nxt[0];
   assign row_c = g_lvl[DEPTH-1].nxt[1];

endmodule

// File: rtl/eomul_cla.sv
module eomul_cla #(
   parameter int W   = 64,
   parameter int GRP = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] sum
);

   localparam int NG = W / GRP;

   if (W % GRP != 0) begin : g_chk_grp
      $error("eomul_cla: W must be a multiple of GRP");
   end

   logic [W-1:0]  gen_b;
   logic [W-1:0]  prp_b;
   logic [W-1:0]  carry;
   logic [NG-1:0] grp_g;
   logic [NG-1:0] grp_p;
   logic [NG:0]   grp_c;

   assign gen_b = x & y;
   assign prp_b = x ^ y;

   // group generate / propagate
   always_comb begin : group_gp
      logic acc, run;
      for (int gi = 0; gi < NG; gi++) begin
         acc = 1'b0;
         run = 1'b1;
         for (int k = GRP - 1; k >= 0; k--) begin
            acc = acc | (run & gen_b[gi*GRP + k]);
            run = run & prp_b[gi*GRP + k];
         end
         grp_g[gi] = acc;
         grp_p[gi] = run;
      end
   end

   // second look-ahead level: carry into every group
   always_comb begin : group_carry
      logic acc, run;
      grp_c[0] = 1'b0;
      for (int i = 0; i < NG; i++) begin
         acc = 1'b0;
         run = 1'b1;
         for (int j = i; j >= 0; j--) begin
            acc = acc | (run & grp_g[j]);
            run = run & grp_p[j];
         end
         grp_c[i+1] = acc;
      end
   end

   // carries inside each group from its own terms and the group carry
   always_comb begin : bit_carry
      logic acc, run;
      for (int gi = 0; gi < NG; gi++) begin
         for (int k = 0; k < GRP; k++) begin
            acc = 1'b0;
            run = 1'b1;
            for (int j = k - 1; j >= 0; j--) begin
               acc = acc | (run & gen_b[gi*GRP + j]);
               run = run & prp_b[gi*GRP + j];
            end
            carry[gi*GRP + k] = acc | (run & grp_c[gi]);
         end
      end
   end

   assign sum = prp_b ^ carry;

   AST_CLA_SUM: assert property (@(posedge clk) disable iff (rst)
      {grp_c[NG], sum} == ({1'b0, x} + {1'b0, y}));                  // R5

endmodule

// File: rtl/eo_mult.sv
module eo_mult
   import eomul_pkg::*;
#(
   parameter int W       = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);

   localparam int PW = 2 * W;
   localparam int NR = 2 * W;

   if (W < 4 || W % 2 != 0) begin : g_chk_w
      $error("eo_mult: W must be even and at least 4");
   end

   logic [W-1:0]  a_even, a_odd, b_even, b_odd;
   logic [PW-1:0] pp_rows [NR];
   logic [PW-1:0] row_s, row_c;
   logic [PW-1:0] sum;

   eomul_split #(.W(W)) u_split_a (
      .clk(clk), .rst(rst), .x(a), .x_even(a_even), .x_odd(a_odd));
   eomul_split #(.W(W)) u_split_b (
      .clk(clk), .rst(rst), .x(b), .x_even(b_even), .x_odd(b_odd));

   eomul_ppgen #(.W(W)) u_ppgen (
      .a_even(a_even), .a_odd(a_odd), .b_even(b_even), .b_odd(b_odd),
      .rows(pp_rows));

   eomul_csa_tree #(.PW(PW), .N(NR)) u_tree (
      .clk(clk), .rst(rst), .rows(pp_rows), .row_s(row_s), .row_c(row_c));

   eomul_cla #(.W(PW), .GRP(4)) u_cla (
      .clk(clk), .rst(rst), .x(row_s), .y(row_c), .sum(sum));

   AST_ROWS_SUM: assert property (@(posedge clk) disable iff (rst)
      (row_s + row_c) == ({{W{1'b0}}, a} * {{W{1'b0}}, b}));         // R1

   if (REG_OUT) begin : g_reg
      logic [PW-1:0] p_q;
      always_ff @(posedge clk) begin
         if (rst) p_q <= '0;
         else     p_q <= sum;
      end
      assign p = p_q;

      AST_REG_LATENCY: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> p == $past({{W{1'b0}}, a} * {{W{1'b0}}, b}));      // R6
      AST_RESET_CLEAR: assert property (@(posedge clk)
         rst |=> p == '0);                                           // R7
   end else begin : g_comb
      assign p = sum;
   end

endmodule

// File: tb/eo_mult_tb.sv
module eo_mult_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [W-1:0]   a = '0;
   logic [W-1:0]   b = '0;
   logic [2*W-1:0] p;

   int n_run  = 0;
   int n_fail = 0;
   logic [2*W-1:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   eo_mult #(.W(W), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst(rst), .a(a), .b(b), .p(p));

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
      return {{W{1'b0}}, x} * {{W{1'b0}}, y};
   endfunction

   task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] expv);
      n_run++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: p=%h expected %h", req, act, expv);
      end
   endtask

   // called at a falling edge: drive, model the register, check one edge later
   task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
      a = x;
      b = y;
      exp_q.push_back(ref_mul(x, y));
      @(negedge clk);
      chk(req, p, exp_q.pop_front());
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [2*W-1:0] held;
      repeat (3) @(negedge clk);
      chk("R7 reset state", p, '0);
      rst = 1'b0;

      // R9 zero and one
      run(32'h0, 32'h0, "R9 zero*zero");
      run(32'h0, 32'hDEADBEEF, "R9 zero*x");
      run(32'h1, 32'hDEADBEEF, "R9 one*x");
      run(32'hCAFEF00D, 32'h1, "R9 x*one");

      // R1 full width
      run(32'hFFFFFFFF, 32'hFFFFFFFF, "R1 ones*ones");
      chk("R1 ones*ones constant", p, 64'hFFFFFFFE00000001);
      run(32'hFFFFFFFF, 32'h2, "R1 ones*two");

      // R3 alternating patterns, one split half empty
      run(32'h55555555, 32'h55555555, "R3 even*even");
      run(32'h55555555, 32'hAAAAAAAA, "R3 even*odd");
      run(32'hAAAAAAAA, 32'h55555555, "R3 odd*even");
      run(32'hAAAAAAAA, 32'hAAAAAAAA, "R3 odd*odd");
      run(32'hAAAAAAAA, 32'hFFFFFFFF, "R3 odd*ones");
      run(32'h55555555, 32'hFFFFFFFF, "R3 even*ones");
      for (int k = 0; k < 200; k++) begin
         logic [W-1:0] x, y;
         x = $urandom() & ((k % 2 == 0) ? 32'h55555555 : 32'hAAAAAAAA);
         y = $urandom() & ((k % 4 < 2) ? 32'hAAAAAAAA : 32'h55555555);
         run(x, y, "R3 masked random");
      end

      // R8 single set bits
      for (int i = 0; i < W; i++) begin
         for (int j = 0; j < W; j++) begin
            run(32'h1 << i, 32'h1 << j, "R8 single bits");
            chk("R8 single bit position", p, 64'h1 << (i + j));
         end
      end

      // R6 output holds between edges
      run(32'h12345678, 32'h9ABCDEF0, "R6 capture");
      held = p;
      a = 32'hFFFFFFFF;
      b = 32'h3;
      #1;
      chk("R6 hold between edges", p, held);
      exp_q.push_back(ref_mul(32'hFFFFFFFF, 32'h3));
      @(negedge clk);
      chk("R6 one edge later", p, exp_q.pop_front());

      // R7 reset overrides inputs
      a = 32'hFFFFFFFF;
      b = 32'hFFFFFFFF;
      rst = 1'b1;
      @(negedge clk);
      chk("R7 reset with inputs", p, '0);
      rst = 1'b0;
      @(negedge clk);
      chk("R7 after reset release", p, ref_mul(32'hFFFFFFFF, 32'hFFFFFFFF));

      // R1 random operands
      for (int k = 0; k < 10000; k++) begin
         run($urandom(), $urandom(), "R1 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule